// File: doc/BRIEF.md
# Dual-Channel Code Latch Controller with Staging Buffer

This block sits behind a serial receiver and turns each committed 16-bit command word into updates of two 12-bit output codes, one for channel A and one for channel B. A third 12-bit register, the staging buffer, holds a pending code for channel B. A command that loads channel A also moves the staged value into channel B in the same clock edge. Software can therefore stage B first and then change both channel codes together with a single A command.

The upper four bits of the word are control bits and the lower twelve bits are the code. Bit 15 selects a channel-A load. When bit 15 is clear, bit 12 chooses between a channel-B load and a stage-only write. Bit 14 is the speed flag and bit 13 is the power-down flag. Both flags are taken from every committed word, whatever the select bits are. A command decoder maps the select bits onto one of three named commands. The commands are LOAD_A (bit 15 = 1), LOAD_B (bits 15 and 12 both 0) and STAGE (bit 15 = 0, bit 12 = 1). Each command turns into write enables for the registers. There is no sequencing state: every commit completes at the clock edge that samples the strobe.

Top module: `dual_code_latch_ctrl`

## Requirements
- R1: While reset is active and after it releases, code_a, code_b, the staging buffer, fast_mode, power_down, upd_a and upd_b are all zero. A LOAD_A issued before any staging copies zero into code_b.
- R2: A commit with bit 15 = 1 (LOAD_A) loads bits 11:0 into code_a and copies the staging buffer into code_b. The staging buffer keeps its value.
- R3: A commit with bit 15 = 0 and bit 12 = 0 (LOAD_B) loads bits 11:0 into both code_b and the staging buffer. code_a is unchanged.
- R4: A commit with bit 15 = 0 and bit 12 = 1 (STAGE) loads bits 11:0 into the staging buffer only. code_a and code_b are unchanged.
- R5: Every commit sets fast_mode to bit 14 of the word (1 = fast, 0 = slow).
- R6: Every commit sets power_down to bit 13 of the word (1 = powered down, 0 = normal).
- R7: upd_a is high for exactly the one cycle after a LOAD_A commit. upd_b is high for exactly the one cycle after a LOAD_A or LOAD_B commit. Both flags are low otherwise.
- R8: With cmt_valid low, no output changes, whatever value cmt_word carries.
- R9: After a STAGE followed by a LOAD_A, code_a and code_b take their new values at the same clock edge.
- R10: Results of a commit are visible at the outputs directly after the rising edge that samples cmt_valid high. There is exactly one register stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cmt_valid | input | 1 | One-cycle strobe marking cmt_word as a committed command |
| cmt_word | input | 16 | Command word: control bits 15:12, code bits 11:0 |
| code_a | output | 12 | Channel A output code |
| code_b | output | 12 | Channel B output code |
| fast_mode | output | 1 | Speed flag, 1 = fast |
| power_down | output | 1 | Power-down flag, 1 = powered down |
| upd_a | output | 1 | One-cycle pulse after code_a is written |
| upd_b | output | 1 | One-cycle pulse after code_b is written |

## Verification
The staging buffer has no port of its own, so its contents can only be seen when a later LOAD_A copies it into code_b. The stimulus therefore places STAGE commands between other commands. It then reads the staged value back through a LOAD_A, in the same commit that changes code_a, which also checks the simultaneous update. A reset in the middle of a run, followed directly by a LOAD_A, shows that the buffer was cleared.

// File: rtl/dlc_pkg.sv
package dlc_pkg;
    parameter int WORD_W = 16;
    parameter int CODE_W = 12;

    localparam int SEL_A_BIT = WORD_W - 1;
    localparam int SPEED_BIT = WORD_W - 2;
    localparam int PDN_BIT   = WORD_W - 3;
    localparam int STAGE_BIT = WORD_W - 4;

    typedef enum logic [1:0] {
        CMD_LOAD_A = 2'd0,
        CMD_LOAD_B = 2'd1,
        CMD_STAGE  = 2'd2
    } cmd_kind_e;

    typedef struct packed {
        logic a;          // write code_a
        logic b;          // write code_b
        logic hold;       // write staging buffer
        logic b_from_hold; // code_b source is staging buffer
    } wr_en_t;
endpackage

// File: rtl/dlc_cmd_decode.sv
module dlc_cmd_decode
    import dlc_pkg::*;
(
    input  logic   sel_a,
    input  logic   stage_only,
    output wr_en_t wr
);
    cmd_kind_e kind;

    always_comb begin
        unique casez ({sel_a, stage_only})
            2'b1?:   kind = CMD_LOAD_A;
            2'b00:   kind = CMD_LOAD_B;
            default: kind = CMD_STAGE;
        endcase
    end

    always_comb begin
        wr = '0;
        unique case (kind)
            CMD_LOAD_A: begin
                wr.a           = 1'b1;
                wr.b           = 1'b1;
                wr.b_from_hold = 1'b1;
            end
            CMD_LOAD_B: begin
                wr.b    = 1'b1;
                wr.hold = 1'b1;
            end
            default: begin
                wr.hold = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/dlc_en_reg.sv
module dlc_en_reg #(
    parameter int             W       = 12,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= RST_VAL;
        else if (en)
            q <= d;
    end
endmodule

// File: rtl/dual_code_latch_ctrl.sv
module dual_code_latch_ctrl
    import dlc_pkg::*;
#(
    parameter int CW = dlc_pkg::CODE_W,
    parameter int WW = dlc_pkg::WORD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmt_valid,
    input  logic [WW-1:0] cmt_word,
    output logic [CW-1:0] code_a,
    output logic [CW-1:0] code_b,
    output logic          fast_mode,
    output logic          power_down,
    output logic          upd_a,
    output logic          upd_b
);
    localparam int NCH = 2;

    wr_en_t        wr;
    logic [CW-1:0] data;
    logic [CW-1:0] hold_q;
    logic [CW-1:0] b_next;
    logic [1:0]    mode_q;
    logic [NCH-1:0] upd_q;

    assign data = cmt_word[CW-1:0];

    dlc_cmd_decode u_dec (
        .sel_a      (cmt_word[SEL_A_BIT]),
        .stage_only (cmt_word[STAGE_BIT]),
        .wr         (wr)
    );

    assign b_next = wr.b_from_hold ? hold_q : data;

    dlc_en_reg #(.W(CW)) u_reg_a (
        .clk(clk), .rst_n(rst_n), .en(cmt_valid & wr.a), .d(data), .q(code_a)
    );

    dlc_en_reg #(.W(CW)) u_reg_b (
        .clk(clk), .rst_n(rst_n), .en(cmt_valid & wr.b), .d(b_next), .q(code_b)
    );

    dlc_en_reg #(.W(CW)) u_reg_hold (
        .clk(clk), .rst_n(rst_n), .en(cmt_valid & wr.hold), .d(data), .q(hold_q)
    );

    dlc_en_reg #(.W(2)) u_reg_mode (
        .clk(clk), .rst_n(rst_n), .en(cmt_valid),
        .d({cmt_word[SPEED_BIT], cmt_word[PDN_BIT]}), .q(mode_q)
    );

    dlc_en_reg #(.W(NCH)) u_reg_upd (
        .clk(clk), .rst_n(rst_n), .en(1'b1),
        .d({cmt_valid & wr.a, cmt_valid & wr.b}), .q(upd_q)
    );

    assign fast_mode  = mode_q[1];
    assign power_down = mode_q[0];
    assign upd_a      = upd_q[1];
    assign upd_b      = upd_q[0];
endmodule

// File: rtl/dual_code_latch_ctrl_chk.sv
module dual_code_latch_ctrl_chk #(
    parameter int CW = 12,
    parameter int WW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmt_valid,
    input logic [WW-1:0] cmt_word,
    input logic [CW-1:0] code_a,
    input logic [CW-1:0] code_b,
    input logic          fast_mode,
    input logic          power_down,
    input logic          upd_a,
    input logic          upd_b
);
    logic is_a, is_b, is_stage;
    assign is_a     = cmt_valid &  cmt_word[WW-1];
    assign is_b     = cmt_valid & ~cmt_word[WW-1] & ~cmt_word[WW-4];
    assign is_stage = cmt_valid & ~cmt_word[WW-1] &  cmt_word[WW-4];

    AST_A_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        is_a |=> code_a == $past(cmt_word[CW-1:0])); // R2
    AST_A_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (is_b || is_stage) |=> $stable(code_a)); // R3
    AST_B_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        is_b |=> code_b == $past(cmt_word[CW-1:0])); // R3
    AST_STAGE_KEEP_B: assert property (@(posedge clk) disable iff (!rst_n)
        is_stage |=> $stable(code_b)); // R4
    AST_SPEED: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_valid |=> fast_mode == $past(cmt_word[WW-2])); // R5
    AST_PDN: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_valid |=> power_down == $past(cmt_word[WW-3])); // R6
    AST_UPD_A: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> upd_a == $past(is_a)); // R7
    AST_UPD_B: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> upd_b == $past(is_a || is_b)); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cmt_valid |=> ($stable(code_a) && $stable(code_b)
                        && $stable(fast_mode) && $stable(power_down))); // R8
endmodule

bind dual_code_latch_ctrl dual_code_latch_ctrl_chk #(.CW(CW), .WW(WW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmt_valid(cmt_valid), .cmt_word(cmt_word),
    .code_a(code_a), .code_b(code_b), .fast_mode(fast_mode),
    .power_down(power_down), .upd_a(upd_a), .upd_b(upd_b)
);

// File: tb/dual_code_latch_ctrl_test.sv
`timescale 1ns/1ps
module dual_code_latch_ctrl_test;
    localparam real HALF = 2.5;
    localparam int  NV   = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmt_valid = 1'b0;
    logic [15:0] cmt_word = '0;
    logic [11:0] code_a, code_b;
    logic        fast_mode, power_down, upd_a, upd_b;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #HALF clk = ~clk;

    dual_code_latch_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cmt_valid(cmt_valid), .cmt_word(cmt_word),
        .code_a(code_a), .code_b(code_b), .fast_mode(fast_mode),
        .power_down(power_down), .upd_a(upd_a), .upd_b(upd_b)
    );

    // {word, exp_a, exp_b, fast, pdn, upd_a, upd_b}
    localparam logic [43:0] VEC [NV] = '{
        {16'h0ABC, 12'h000, 12'hABC, 4'b0001}, // R3 load B from reset
        {16'hC123, 12'h123, 12'hABC, 4'b1011}, // R2 R5 load A, B from stage
        {16'h1555, 12'h123, 12'hABC, 4'b0000}, // R4 stage only
        {16'h5777, 12'h123, 12'hABC, 4'b1000}, // R4 R5 restage
        {16'h8800, 12'h800, 12'h777, 4'b0011}, // R9 both change together
        {16'hA001, 12'h001, 12'h777, 4'b0111}, // R6 R2 stage kept
        {16'h2FFF, 12'h001, 12'hFFF, 4'b0101}, // R3 R6
        {16'hF000, 12'h000, 12'hFFF, 4'b1111}, // R2 R5 R6 R7
        {16'h3000, 12'h000, 12'hFFF, 4'b0100}, // R4
        {16'h4ABC, 12'h000, 12'hABC, 4'b1001}, // R3 R5
        {16'h9FFF, 12'hFFF, 12'hABC, 4'b0011}  // R2 stage from R3
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_all(input string req, input logic [11:0] ea, input logic [11:0] eb,
                           input logic [3:0] fl);
        chk({req, " code_a"}, {4'h0, code_a}, {4'h0, ea});
        chk({req, " code_b"}, {4'h0, code_b}, {4'h0, eb});
        chk({req, " flags"}, {12'h0, fast_mode, power_down, upd_a, upd_b}, {12'h0, fl});
    endtask

    task automatic commit(input logic [15:0] w);
        @(negedge clk);
        cmt_valid = 1'b1;
        cmt_word  = w;
        @(negedge clk);
        cmt_valid = 1'b0;
        cmt_word  = ~w;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk_all("R1 in reset", 12'h000, 12'h000, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R1 after reset", 12'h000, 12'h000, 4'b0000);

        for (int i = 0; i < NV; i++) begin
            commit(VEC[i][43:28]);
            chk_all($sformatf("R10 vec%0d", i), VEC[i][27:16], VEC[i][15:4], VEC[i][3:0]);
        end

        // R7: pulse lasts one cycle only
        @(negedge clk);
        chk_all("R7 pulse ends", 12'hFFF, 12'hABC, 4'b0000);

        // R8: junk words without strobe
        commit(16'h1321); // stage 321
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            cmt_word = 16'hE000 | 16'(k * 16'h0111);
            chk_all("R8 idle", 12'hFFF, 12'hABC, 4'b0000);
        end
        commit(16'h8456);
        chk_all("R8 stage intact", 12'h456, 12'h321, 4'b0011);

        // R1: reset mid-run clears staging buffer
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk_all("R1 mid reset", 12'h000, 12'h000, 4'b0000);
        rst_n = 1'b1;
        commit(16'hC7AA);
        chk_all("R1 stage cleared", 12'h7AA, 12'h000, 4'b1011);

        // R9: stage then A with same values twice
        commit(16'h1BEE);
        chk_all("R9 staged", 12'h7AA, 12'h000, 4'b0000);
        commit(16'h8C0D);
        chk_all("R9 together", 12'hC0D, 12'hBEE, 4'b0011);

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(HALF * 2 * 20000);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule